// File: doc/BRIEF.md
# Modulo 2^n+1 Fused Dot-Product Unit

This block computes the inner product of two equal-length vectors of residues and reduces it modulo 2^N+1 in a single combinational datapath. It has no per-element multipliers or accumulator. For every element pair it forms N weighted rows directly in the residue domain: bits that wrap past weight 2^N come back inverted at the low end. All rows from all pairs, plus one constant correction row, go into one carry-save reduction array. Each 3:2 stage returns its top carry inverted into bit 0. A compare-and-subtract adder turns the final pair of vectors into a fully reduced residue.

Each operand is N+1 bits wide and may take any value from 0 to 2^N. The value 2^N is congruent to -1 and is handled by rewriting the first two rows of that pair, so no extra correction logic is needed. The operands are sampled when `in_valid` is high. The residue and its valid flag come out of one output register on the next clock.

Top module: `mod_dot_unit`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `result` equals the sum over i of a_i·b_i, reduced modulo 2^N+1 (17 in the default configuration).
- R2: `out_valid` is high in exactly the cycles that follow a clock edge where `in_valid` was high. With `in_valid` held high, a new result appears every clock.
- R3: `result` always lies in 0..2^N. A sum congruent to 2^N is output as 2^N, never as a wider value.
- R4: An operand of value 2^N (only bit N set) acts as -1. Paired with x it contributes (2^N+1-x) mod (2^N+1), and 2^N·2^N contributes 1. Operands above 2^N are outside the contract.
- R5: All-zero operand vectors give a result of 0.
- R6: While `in_valid` is low, `result` keeps its last value, whatever the operand inputs do.
- R7: While `rst_n` is low at a clock edge, `result` and `out_valid` clear to 0 on that edge (synchronous, active low). This takes priority over `in_valid`.
- R8: Element i of each vector occupies bits [i*(N+1) +: N+1] of `a_vec` / `b_vec`. Only elements with the same index are multiplied together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand vectors are sampled on this cycle |
| a_vec | input | P*(N+1) | First vector, P packed residues of N+1 bits |
| b_vec | input | P*(N+1) | Second vector, same packing |
| out_valid | output | 1 | `result` holds a new value this cycle |
| result | output | N+1 | Reduced dot product, 0..2^N |

## Verification
The bench uses vectors with a single active pair to check the row generation and end-around inversion of one multiplication alone. Vectors whose non-zero elements sit at different indices separate correct slot pairing from cross-products. Operands of 2^N, alone and against ordinary values, exercise the two-row rewrite for the -1 encoding. All-15 vectors push the sum to the residue 2^N and test the top of the output range. Several hundred back-to-back random vectors, biased towards 0 and 2^N, exercise many mixtures of carries through the array. Idle cycles with changing operands and a reset asserted during a valid cycle show that the output register holds its value and that reset takes priority.

// File: rtl/mod_dot_pkg.sv
// Package: constants shared by the modulo 2^N+1 dot-product datapath.
// Assumes N >= 2 and P*N >= 2 so that the carry-save array has at least one stage.
package mod_dot_pkg;

    // Residue that the constant row plus the final-adder carry-in must supply.
    // Each pair's rows carry a bias of 2^N-1-N and each 3:2 stage adds +1.
    function automatic int unsigned needed_bias(input int unsigned n, input int unsigned p);
        int unsigned modv;
        int unsigned offs;
        modv = (32'd1 << n) + 32'd1;
        offs = p * ((32'd1 << n) - 32'd1 - n) + (p * n - 32'd1);
        return (modv - (offs % modv)) % modv;
    endfunction

    // Value of the constant row (limited to N bits).
    function automatic int unsigned corr_row(input int unsigned n, input int unsigned p);
        int unsigned need;
        need = needed_bias(n, p);
        return (need == (32'd1 << n)) ? need - 32'd1 : need;
    endfunction

    // Carry-in to the final adder when the bias does not fit N bits.
    function automatic int unsigned corr_cin(input int unsigned n, input int unsigned p);
        return (needed_bias(n, p) == (32'd1 << n)) ? 32'd1 : 32'd0;
    endfunction

endpackage

// File: rtl/mod_pp_rows.sv
// Module: builds the N partial-product rows of one element pair modulo 2^N+1.
// Row j is operand a shifted left by j. Bits pushed past weight 2^N wrap into
// the low positions inverted, which gives each row a known bias of 2^j-1.
// An operand equal to 2^N (= -1) is handled by rewriting rows 0 and 1 so that
// the pair keeps the same total bias. Assumes each operand is at most 2^N.
module mod_pp_rows #(
    parameter int N = 4
) (
    input  logic [N:0]           a_op,
    input  logic [N:0]           b_op,
    output logic [N-1:0][N-1:0]  rows
);
    logic [N-1:0]          a_lo;
    logic [N-1:0]          b_lo;
    logic                  neg_one;   // exactly one operand is 2^N
    logic                  both_top;  // both operands are 2^N
    logic [N-1:0]          other_op;  // the operand that is not 2^N
    logic [N-1:0][N-1:0]   base;

    assign a_lo     = a_op[N-1:0];
    assign b_lo     = b_op[N-1:0];
    assign neg_one  = a_op[N] ^ b_op[N];
    assign both_top = a_op[N] & b_op[N];
    assign other_op = a_op[N] ? b_lo : a_lo;

    // Rotated AND rows, with inverted (NAND) bits in the wrapped positions.
    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar k = 0; k < N; k++) begin : g_bit
            if (k >= j) begin : g_straight
                assign base[j][k] = a_lo[k-j] & b_lo[j];
            end else begin : g_wrapped
                assign base[j][k] = ~(a_lo[k-j+N] & b_lo[j]);
            end
        end
    end

    // Row 0 takes ~x (= -x-2) for a -1 operand, or 1 for (-1)*(-1).
    assign rows[0] = base[0] | ({N{neg_one}} & ~other_op) | N'(both_top);
    // Row 1 gains +2 in the -1 case to restore the pair bias.
    assign rows[1] = base[1] | (N'(neg_one) << 1);
    for (genvar j = 2; j < N; j++) begin : g_pass
        assign rows[j] = base[j];
    end

endmodule

// File: rtl/mod_csa_ieac.sv
// Module: one 3:2 carry-save stage modulo 2^N+1 with an inverted end-around carry.
// The carry out of bit N-1 is inverted and placed at bit 0 of the carry vector.
// So s + c is congruent to x + y + z + 1 modulo 2^N+1.
module mod_csa_ieac #(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    output logic [N-1:0] s,
    output logic [N-1:0] c
);
    logic [N-1:0] maj;

    // Bitwise full-adder sum and majority.
    assign s   = x ^ y ^ z;
    assign maj = (x & y) | (x & z) | (y & z);
    // Shift the carries up one place and bring the top carry back inverted.
    assign c   = {maj[N-2:0], ~maj[N-1]};

endmodule

// File: rtl/mod_final_add.sv
// Module: adds two N-bit vectors plus a carry-in and reduces the sum modulo 2^N+1.
// The sum is below 2*(2^N+1), so one conditional subtraction is enough.
module mod_final_add #(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         cin,
    output logic [N:0]   r
);
    localparam logic [N:0] MODV = (N+1)'((1 << N) + 1);

    logic [N:0] tot;
    logic [N:0] diff;

    // Plain sum, then select the sum or the sum minus the modulus.
    assign tot  = {1'b0, x} + {1'b0, y} + {{N{1'b0}}, cin};
    assign diff = tot - MODV;
    assign r    = (tot >= MODV) ? diff : tot;

endmodule

// File: rtl/mod_dot_unit.sv
// Module: fused modulo 2^N+1 dot product of two P-element vectors.
// All partial-product rows and one constant bias row pass through a single
// inverted end-around-carry carry-save array, followed by one modulo adder
// and one output register. Assumes every operand is in 0..2^N.
module mod_dot_unit
    import mod_dot_pkg::*;
#(
    parameter int N = 4,
    parameter int P = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [P*(N+1)-1:0] a_vec,
    input  logic [P*(N+1)-1:0] b_vec,
    output logic             out_valid,
    output logic [N:0]       result
);
    localparam int          W      = N + 1;
    localparam int          NROWS  = P * N;
    localparam int          NSTAGE = NROWS - 1;
    localparam logic [N-1:0] CORR  = N'(corr_row(N, P));
    localparam logic        CIN    = 1'(corr_cin(N, P));
    localparam logic [N:0]  MAXV   = W'(1 << N);

    logic [N-1:0] all_rows [NROWS+1];
    logic [N-1:0] acc_s    [NSTAGE+1];
    logic [N-1:0] acc_c    [NSTAGE+1];
    logic [N:0]   dot_res;

    // Constant bias row occupies slot 0 of the array input.
    assign all_rows[0] = CORR;

    // Partial-product rows for every element pair.
    for (genvar i = 0; i < P; i++) begin : g_pair
        logic [N-1:0][N-1:0] pp;
        mod_pp_rows #(.N(N)) u_rows (
            .a_op (a_vec[i*W +: W]),
            .b_op (b_vec[i*W +: W]),
            .rows (pp)
        );
        for (genvar j = 0; j < N; j++) begin : g_link
            assign all_rows[1 + i*N + j] = pp[j];
        end
    end

    // Carry-save array: each stage folds in one further row.
    assign acc_s[0] = all_rows[0];
    assign acc_c[0] = all_rows[1];
    for (genvar t = 0; t < NSTAGE; t++) begin : g_stage
        mod_csa_ieac #(.N(N)) u_csa (
            .x (acc_s[t]),
            .y (acc_c[t]),
            .z (all_rows[t+2]),
            .s (acc_s[t+1]),
            .c (acc_c[t+1])
        );
    end

    mod_final_add #(.N(N)) u_final (
        .x   (acc_s[NSTAGE]),
        .y   (acc_c[NSTAGE]),
        .cin (CIN),
        .r   (dot_res)
    );

    // Output register: loads on a valid strobe, holds otherwise, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= dot_res;
            end
        end
    end

    // R2: valid follows the strobe by one clock.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: the registered residue never exceeds 2^N.
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result <= MAXV));

    // R6: no strobe, no change of the output value.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R7: reset clears the output register on the next edge.
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R4: sampled operands stay inside the 0..2^N contract.
    for (genvar i = 0; i < P; i++) begin : g_range
        a_r4_operand_range: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (a_vec[i*W +: W] <= MAXV && b_vec[i*W +: W] <= MAXV));
    end

endmodule

// File: tb/mod_dot_unit_tb.sv
`timescale 1ns/1ps
// Bench: table-driven and random checks of mod_dot_unit in its default configuration.
module mod_dot_unit_tb;
    localparam int N    = 4;
    localparam int P    = 4;
    localparam int W    = N + 1;
    localparam int MODV = (1 << N) + 1;
    localparam int NTAB = 10;

    // Stimulus table: element values of a and b per row.
    localparam int TAB_A [NTAB][P] = '{
        '{3, 0, 0, 0},  '{0, 0, 0, 0},      '{16, 16, 16, 16}, '{16, 0, 0, 0},
        '{0, 0, 0, 2},  '{9, 0, 0, 0},      '{15, 15, 15, 15}, '{1, 2, 3, 4},
        '{16, 7, 0, 16}, '{8, 4, 2, 1}
    };
    localparam int TAB_B [NTAB][P] = '{
        '{5, 0, 0, 0},  '{0, 0, 0, 0},      '{16, 16, 16, 16}, '{5, 0, 0, 0},
        '{0, 0, 0, 7},  '{0, 9, 0, 0},      '{15, 15, 15, 15}, '{5, 6, 7, 8},
        '{16, 16, 11, 3}, '{16, 16, 16, 16}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [P*W-1:0]   a_vec;
    logic [P*W-1:0]   b_vec;
    logic             out_valid;
    logic [N:0]       result;

    int n_chk  = 0;
    int n_fail = 0;

    mod_dot_unit #(.N(N), .P(P)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_vec     (a_vec),
        .b_vec     (b_vec),
        .out_valid (out_valid),
        .result    (result)
    );

    always #10 clk = ~clk;

    // Behavioural model: plain sum of products, then remainder.
    function automatic int ref_dot(input logic [P*W-1:0] av, input logic [P*W-1:0] bv);
        int s = 0;
        for (int i = 0; i < P; i++) s += int'(av[i*W +: W]) * int'(bv[i*W +: W]);
        return s % MODV;
    endfunction

    // Requirement that each table row targets.
    function automatic string tag_of(input int v);
        case (v)
            1:          return "R5";
            2, 3, 8, 9: return "R4";
            4, 5:       return "R8";
            6:          return "R3";
            default:    return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive a vector, then check one clock later (R1, R2).
    task automatic apply(input logic [P*W-1:0] av, input logic [P*W-1:0] bv, input string req);
        int exp;
        a_vec    = av;
        b_vec    = bv;
        in_valid = 1'b1;
        exp      = ref_dot(av, bv);
        @(negedge clk);
        check(out_valid == 1'b1, "R2", int'(out_valid), 1);
        check(int'(result) == exp, req, int'(result), exp);
    endtask

    initial begin : main
        logic [P*W-1:0] av;
        logic [P*W-1:0] bv;
        logic [N:0]     held;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        a_vec    = '0;
        b_vec    = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        check(result == '0, "R7", int'(result), 0);
        rst_n = 1'b1;

        // Table walk, back-to-back strobes.
        for (int v = 0; v < NTAB; v++) begin
            for (int i = 0; i < P; i++) begin
                av[i*W +: W] = W'(TAB_A[v][i]);
                bv[i*W +: W] = W'(TAB_B[v][i]);
            end
            apply(av, bv, tag_of(v));
        end

        // R6: idle with changing operands, result must hold; R2: valid drops.
        held     = result;
        in_valid = 1'b0;
        a_vec    = {P{5'd7}};
        b_vec    = {P{5'd16}};
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        a_vec = {P{5'd3}};
        repeat (2) @(negedge clk);
        check(result == held, "R6", int'(result), int'(held));

        // R7: reset wins over a valid strobe.
        a_vec    = {P{5'd9}};
        b_vec    = {P{5'd9}};
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        check(result == '0, "R7", int'(result), 0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        // R1/R4: random vectors biased towards 0 and 2^N.
        for (int r = 0; r < 400; r++) begin
            for (int i = 0; i < P; i++) begin
                av[i*W +: W] = ($urandom_range(3, 0) == 0) ? W'($urandom_range(1, 0) * 16)
                                                          : W'($urandom_range(16, 0));
                bv[i*W +: W] = ($urandom_range(3, 0) == 0) ? W'($urandom_range(1, 0) * 16)
                                                          : W'($urandom_range(16, 0));
            end
            apply(av, bv, "R1");
        end
        in_valid = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule